// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Master

This block sits on the host side of a two-wire serial bus. It is started once a command that begins a nonvolatile write in a slave has been sent in full. From then on it probes the slave again and again until the slave answers its address, which shows that the internal write cycle is over. Each probe is a START condition followed by the slave address byte with the direction bit cleared. If the address is not acknowledged, the probe is closed with a STOP and a new probe begins. If the address is acknowledged, the sequencer does one of two things. When the host flagged a follow-up operation, it sends the supplied instruction byte straight away on the same transfer, without a STOP. Otherwise it closes the bus with a STOP.

The bus itself is abstracted as a byte engine with a valid/ready command channel. Each command carries an operation code and a data byte. The engine returns one response per command, and that response carries an acknowledge bit. A configurable budget caps the number of probes. When the budget runs out, the sequencer closes the bus and reports a timeout instead of completion. A busy flag covers the whole episode, from the accepted start request to the completion or timeout pulse.

Top module: `ack_poll_master`

## Requirements
- R1: Reset is synchronous and active high. It clears busy_o, done_o, err_o and cmd_valid_o.
- R2: A start_i pulse seen while idle captures slave_addr_i, more_op_i and instr_i, and busy_o reads high on the following cycle. A start_i seen while busy is ignored, and the captured values do not change.
- R3: Every probe issues a START command (cmd_op_o = 0) and then a byte command (cmd_op_o = 1) whose data is the 7-bit address in bits 7:1 with bit 0 = 0.
- R4: When the address byte response has rsp_ack_i = 0 and the probe budget is not used up, a STOP command (cmd_op_o = 2) follows, and then a new probe.
- R5: When the address is acknowledged and the captured follow-up flag is 1, the next command is a byte command carrying the captured instruction. No STOP is sent, and done_o pulses after its response.
- R6: When the address is acknowledged and the captured follow-up flag is 0, a STOP command follows, and done_o pulses after its response.
- R7: After MAX_POLLS probes have all been refused, a STOP is issued and err_o pulses instead of done_o. No further probe starts.
- R8: done_o and err_o are one-cycle pulses that never occur together. busy_o is low in the cycle that either pulse is high, and it stays high from acceptance of the start request until then.
- R9: cmd_valid_o, cmd_op_o and cmd_data_o hold steady until cmd_ready_i is seen. No new command is offered until the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (accepted only while idle) |
| slave_addr_i | input | ADDR_W | 7-bit slave address |
| more_op_i | input | 1 | 1: send an instruction byte after the acknowledge |
| instr_i | input | DATA_W | Instruction byte for the follow-up operation |
| busy_o | output | 1 | Polling episode in progress |
| done_o | output | 1 | Pulse: slave acknowledged, sequence closed |
| err_o | output | 1 | Pulse: probe budget exhausted |
| cmd_valid_o | output | 1 | Command offered to the byte engine |
| cmd_ready_i | input | 1 | Byte engine takes the command |
| cmd_op_o | output | 2 | 0 START, 1 send byte, 2 STOP |
| cmd_data_o | output | DATA_W | Byte to send for op 1 |
| rsp_valid_i | input | 1 | Byte engine finished the command |
| rsp_ack_i | input | 1 | Acknowledge bit of a byte command |

## Verification
The assertions rely on the byte engine behaving in a particular way. It returns exactly one response per accepted command. It raises rsp_valid_i only after that command's handshake. It does not withdraw cmd_ready_i in a way that matters, because the sequencer holds its offer in any case. The bench's engine model follows these rules: it takes a command after a chosen number of wait cycles and answers it two cycles later. Its acknowledge decision depends only on how many address bytes it has already refused. The sweep runs the refusal count from zero to beyond the budget, covers both settings of the follow-up flag, and varies the ready latency. One run injects a second start request in the middle of polling.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;

  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_BYTE  = 2'd1,
    BUS_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_START = 3'd1,
    SQ_ADDR  = 3'd2,
    SQ_INSTR = 3'd3,
    SQ_STOP  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    END_RETRY = 2'd0,
    END_DONE  = 2'd1,
    END_FAIL  = 2'd2
  } stop_kind_e;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_SEND = 2'd1,
    LK_WAIT = 2'd2
  } link_state_e;

endpackage

// File: rtl/poll_link.sv
module poll_link
  import ack_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  bus_op_e           op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output bus_op_e           cmd_op_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i,
  output logic              fin_o,
  output logic              fin_ack_o
);

  link_state_e lk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q        <= LK_IDLE;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= BUS_START;
      cmd_data_o  <= '0;
      fin_o       <= 1'b0;
      fin_ack_o   <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      unique case (lk_q)
        LK_IDLE: begin
          if (issue_i) begin
            cmd_valid_o <= 1'b1;
            cmd_op_o    <= op_i;
            cmd_data_o  <= data_i;
            lk_q        <= LK_SEND;
          end
        end
        LK_SEND: begin
          if (cmd_ready_i) begin
            cmd_valid_o <= 1'b0;
            lk_q        <= LK_WAIT;
          end
        end
        LK_WAIT: begin
          if (rsp_valid_i) begin
            fin_o     <= 1'b1;
            fin_ack_o <= rsp_ack_i;
            lk_q      <= LK_IDLE;
          end
        end
        default: lk_q <= LK_IDLE;
      endcase
    end
  end

  // R9: an offered command stays put until it is taken
  assert_offer_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)));

  // R9: the sequencer only hands over a command while the link is free
  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (lk_q == LK_IDLE));

endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int MAX_POLLS = 8,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             bump_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_o <= '0;
    end else if (bump_i && (count_o != CNT_W'(MAX_POLLS))) begin
      count_o <= count_o + 1'b1;
    end
  end

  assign last_o = (count_o == LAST_IDX);

  // R7: the refusal tally never passes the budget
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count_o <= CNT_W'(MAX_POLLS));

endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import ack_poll_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              more_op_i,
  input  logic [DATA_W-1:0] instr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              issue_o,
  output bus_op_e           op_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              fin_i,
  input  logic              fin_ack_i,
  output logic              clear_o,
  output logic              bump_o,
  input  logic              last_i
);

  localparam int PAD_W = DATA_W - ADDR_W - 1;

  seq_state_e        st_q;
  stop_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              more_q;
  logic [DATA_W-1:0] instr_q;
  logic [DATA_W-1:0] addr_byte;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_byte = {{PAD_W{1'b0}}, addr_q, 1'b0};
    end else begin : g_nopad
      assign addr_byte = {addr_q, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      kind_q  <= END_RETRY;
      addr_q  <= '0;
      more_q  <= 1'b0;
      instr_q <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      issue_o <= 1'b0;
      op_o    <= BUS_START;
      data_o  <= '0;
      clear_o <= 1'b0;
      bump_o  <= 1'b0;
    end else begin
      issue_o <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      clear_o <= 1'b0;
      bump_o  <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            addr_q  <= slave_addr_i;
            more_q  <= more_op_i;
            instr_q <= instr_i;
            busy_o  <= 1'b1;
            clear_o <= 1'b1;
            issue_o <= 1'b1;
            op_o    <= BUS_START;
            data_o  <= '0;
            st_q    <= SQ_START;
          end
        end
        SQ_START: begin
          if (fin_i) begin
            issue_o <= 1'b1;
            op_o    <= BUS_BYTE;
            data_o  <= addr_byte;
            st_q    <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          if (fin_i) begin
            issue_o <= 1'b1;
            if (fin_ack_i && more_q) begin
              op_o   <= BUS_BYTE;
              data_o <= instr_q;
              st_q   <= SQ_INSTR;
            end else begin
              op_o   <= BUS_STOP;
              data_o <= '0;
              st_q   <= SQ_STOP;
              if (fin_ack_i) begin
                kind_q <= END_DONE;
              end else begin
                bump_o <= 1'b1;
                kind_q <= last_i ? END_FAIL : END_RETRY;
              end
            end
          end
        end
        SQ_INSTR: begin
          if (fin_i) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st_q   <= SQ_IDLE;
          end
        end
        SQ_STOP: begin
          if (fin_i) begin
            unique case (kind_q)
              END_RETRY: begin
                issue_o <= 1'b1;
                op_o    <= BUS_START;
                data_o  <= '0;
                st_q    <= SQ_START;
              end
              END_DONE: begin
                done_o <= 1'b1;
                busy_o <= 1'b0;
                st_q   <= SQ_IDLE;
              end
              default: begin
                err_o  <= 1'b1;
                busy_o <= 1'b0;
                st_q   <= SQ_IDLE;
              end
            endcase
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R2: captured request is frozen for the whole episode
  assert_capture_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(addr_q) && $stable(more_q) && $stable(instr_q)));

  // R2: busy only rises in answer to a start request
  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R8: a finishing pulse always closes an active episode
  assert_finish_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o || err_o) |-> ($past(busy_o) && !busy_o));

endmodule

// File: rtl/ack_poll_master.sv
module ack_poll_master
  import ack_poll_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int MAX_POLLS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              more_op_i,
  input  logic [DATA_W-1:0] instr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic              issue;
  bus_op_e           issue_op;
  logic [DATA_W-1:0] issue_data;
  logic              fin;
  logic              fin_ack;
  logic              b_clear;
  logic              b_bump;
  logic              b_last;
  logic [CNT_W-1:0]  b_count;
  bus_op_e           link_op;

  poll_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .slave_addr_i(slave_addr_i),
    .more_op_i   (more_op_i),
    .instr_i     (instr_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .issue_o     (issue),
    .op_o        (issue_op),
    .data_o      (issue_data),
    .fin_i       (fin),
    .fin_ack_i   (fin_ack),
    .clear_o     (b_clear),
    .bump_o      (b_bump),
    .last_i      (b_last)
  );

  poll_budget #(
    .MAX_POLLS(MAX_POLLS),
    .CNT_W    (CNT_W)
  ) budget_i (
    .clk    (clk),
    .rst    (rst),
    .clear_i(b_clear),
    .bump_i (b_bump),
    .count_o(b_count),
    .last_o (b_last)
  );

  poll_link #(
    .DATA_W(DATA_W)
  ) link_i (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue),
    .op_i       (issue_op),
    .data_i     (issue_data),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_op_o   (link_op),
    .cmd_data_o (cmd_data_o),
    .rsp_valid_i(rsp_valid_i),
    .rsp_ack_i  (rsp_ack_i),
    .fin_o      (fin),
    .fin_ack_o  (fin_ack)
  );

  assign cmd_op_o = link_op;

  // R8: completion and timeout are exclusive
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, err_o}));

  // R8: the bus is only driven during an episode
  assert_offer_in_episode_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> busy_o);

  // R7: timeout only after the whole budget was refused
  assert_timeout_budget_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (b_count == CNT_W'(MAX_POLLS)));

endmodule

// File: tb/ack_poll_master_tb.sv
module ack_poll_master_tb_top;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int MAXP   = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              start_i;
  logic [ADDR_W-1:0] slave_addr_i;
  logic              more_op_i;
  logic [DATA_W-1:0] instr_i;
  logic              busy_o, done_o, err_o;
  logic              cmd_valid_o, cmd_ready_i;
  logic [1:0]        cmd_op_o;
  logic [DATA_W-1:0] cmd_data_o;
  logic              rsp_valid_i, rsp_ack_i;

  always #4 clk = ~clk;

  ack_poll_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(MAXP)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .slave_addr_i(slave_addr_i),
    .more_op_i(more_op_i), .instr_i(instr_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o), .rsp_valid_i(rsp_valid_i),
    .rsp_ack_i(rsp_ack_i)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [1:0] log_op [64];
  logic [7:0] log_dat [64];
  int log_len;
  int nack_target;
  int addr_seen;
  int lat;
  int overlap_err;
  logic [1:0] prev_op;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // byte engine model
  initial begin
    cmd_ready_i = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_ack_i   = 1'b0;
    prev_op     = 2'd2;
    forever begin
      @(negedge clk);
      if (cmd_valid_o && !rst) begin
        repeat (lat) @(negedge clk);
        cmd_ready_i = 1'b1;
        log_op[log_len]  = cmd_op_o;
        log_dat[log_len] = cmd_data_o;
        if (log_len < 63) log_len++;
        @(negedge clk);
        cmd_ready_i = 1'b0;
        @(negedge clk);
        if (cmd_valid_o) overlap_err++;
        rsp_valid_i = 1'b1;
        if (log_op[log_len-1] == 2'd1 && prev_op == 2'd0) begin
          rsp_ack_i = (addr_seen >= nack_target);
          addr_seen++;
        end else begin
          rsp_ack_i = (log_op[log_len-1] == 2'd1);
        end
        prev_op = log_op[log_len-1];
        @(negedge clk);
        rsp_valid_i = 1'b0;
        rsp_ack_i   = 1'b0;
      end
    end
  end

  task automatic run_case(input logic [6:0] addr, input logic [7:0] instr,
                          input bit more, input int nacks, input int latency,
                          input bit poke);
    logic [1:0] eo [64];
    logic [7:0] ed [64];
    int el = 0;
    int attempts;
    bit timeout;
    bit got_done = 0, got_err = 0, busy_at_end = 1;
    int wait_n = 0;
    timeout  = (nacks >= MAXP);
    attempts = timeout ? MAXP : nacks + 1;
    for (int i = 0; i < attempts; i++) begin
      eo[el] = 2'd0; ed[el] = 8'h00; el++;
      eo[el] = 2'd1; ed[el] = {addr, 1'b0}; el++;
      if (i < nacks) begin eo[el] = 2'd2; ed[el] = 8'h00; el++; end
    end
    if (!timeout) begin
      if (more) begin eo[el] = 2'd1; ed[el] = instr; el++; end
      else begin eo[el] = 2'd2; ed[el] = 8'h00; el++; end
    end

    log_len = 0; addr_seen = 0; nack_target = nacks; lat = latency;
    overlap_err = 0; prev_op = 2'd2;
    @(negedge clk);
    slave_addr_i = addr; more_op_i = more; instr_i = instr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      slave_addr_i = ~addr; more_op_i = ~more; instr_i = ~instr; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!(done_o || err_o) && wait_n < 3000) begin
      @(negedge clk);
      wait_n++;
    end
    got_done = done_o; got_err = err_o; busy_at_end = busy_o;
    check(got_done == !timeout, timeout ? "R7" : (more ? "R5" : "R6"),
          "done pulse", got_done, !timeout);
    check(got_err == timeout, "R7", "err pulse", got_err, timeout);
    check(busy_at_end == 1'b0, "R8", "busy at finish", busy_at_end, 0);
    @(negedge clk);
    check(done_o == 1'b0 && err_o == 1'b0, "R8", "pulse width",
          done_o + err_o, 0);
    repeat (6) @(negedge clk);
    check(log_len == el, "R4", "command count", log_len, el);
    check(overlap_err == 0, "R9", "offer during wait", overlap_err, 0);
    for (int i = 0; i < el && i < log_len; i++) begin
      check(log_op[i] == eo[i], poke ? "R2" : "R3", "op", log_op[i], eo[i]);
      check(log_dat[i] == ed[i], poke ? "R2" : (eo[i] == 2'd1 && i == el-1 && more && !timeout) ? "R5" : "R3",
            "data", log_dat[i], ed[i]);
    end
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; slave_addr_i = '0; more_op_i = 1'b0;
    instr_i = '0; lat = 0; nack_target = 0; addr_seen = 0; log_len = 0;
    overlap_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0 && err_o == 0 && cmd_valid_o == 0,
          "R1", "reset outputs", {busy_o, done_o, err_o, cmd_valid_o}, 0);
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n <= MAXP + 1; n++) begin
        run_case(7'h28 + 7'(n), 8'hA0 + 8'(n), m[0], n, (n + m) % 3, 1'b0);
      end
    end
    run_case(7'h55, 8'h3C, 1'b1, 2, 1, 1'b1);
    run_case(7'h12, 8'hC3, 1'b0, MAXP - 1, 2, 1'b1);
    finish_run();
  end

endmodule